// File: doc/BRIEF.md
# Command-Response Buffer Register Block

This block is the device side of a memory-mapped command-response buffer interface for a security coprocessor. A host issues 32-bit reads and writes into a 4 KB register window per locality. Only locality 0 is live. Accesses to any other locality read zero and change nothing.

Within the window the host finds several things. An interface-identification register lets the host select this interface and then lock that choice. A command-ready request bit is cleared by the device. A start bit stays set while a command is in flight. An error flag in the control status register reports a failed command. A set of read-only size and address registers describes one shared command/response buffer. That buffer is held in the block at offset 0x80.

A backend port stands in for the coprocessor. The block sends it a one-cycle start pulse. The backend answers with a done or an error strobe, and that strobe ends the command.

Top module: `crb_regblock`

## Requirements
- R1: After reset, the request bit, start bit, error bit, select and lock are all 0. The interface ID register (offset 0x30) reads with type field [3:0] = 0, bit 14 = 1, bit 17 = 0 and bit 19 = 0.
- R2: While the interface is unlocked, a write to offset 0x30 with bit 19 = 0 sets the select state to bit 17 of the written data. When select is 1, the ID reads with [3:0] = 1 and bit 17 = 1.
- R3: A write to offset 0x30 with bit 19 = 1 sets the lock, which reads back on bit 19. Once locked, every later write to offset 0x30 leaves select and lock unchanged until reset.
- R4: A write of 1 in bit 0 to offset 0x40 makes bit 0 of that register read 1 in the cycle after the write. It reads 0 one cycle later.
- R5: A write of 1 in bit 0 to offset 0x4C while idle does two things. The backend start output goes high for exactly one cycle, and bit 0 of offset 0x4C reads 1. That bit returns to 0 in the cycle after the backend done or error strobe.
- R6: If the error strobe ends a command, bit 0 of offset 0x44 reads 1. If done ends it, that bit reads 0. A new start clears the bit.
- R7: Backend done or error strobes that arrive while no command is in flight change neither the start bit nor the error bit. A start write made while a command is in flight is ignored and gives no new start pulse.
- R8: Offsets 0x58 and 0x64 read 4*BUF_WORDS. Offsets 0x5C and 0x68 read BASE_ADDR + 0x80. Offset 0x60 reads 0.
- R9: Each word at offset 0x80 + 4*i, for i below BUF_WORDS, reads back the last value written to it.
- R10: Offsets with no defined function, including the stub registers, read 0. Writes to them change no readable state.
- R11: Accesses whose locality field (address bits above 11) is not 0 read 0 and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | LOC_W+12 | Byte address: locality above bit 11, offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| be_start | output | 1 | One-cycle pulse to the backend when a command starts |
| be_done | input | 1 | Backend reports successful completion |
| be_err | input | 1 | Backend reports failed completion |

## Verification
The case hardest to reach from the ports is a completion strobe that coincides with, or misses, the in-flight window. A strobe that arrives while idle must be harmless, and a second start write while busy must be dropped. The bench drives backend replies after random latencies and injects stray strobes between commands. It also drives a start write between the pulse and the reply. The lock state can be reached in only one order per reset, so the bench resets twice: once to lock before selecting, and once to select and then lock.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam logic [11:0] OFF_IFID  = 12'h030;
  localparam logic [11:0] OFF_REQ   = 12'h040;
  localparam logic [11:0] OFF_STS   = 12'h044;
  localparam logic [11:0] OFF_START = 12'h04C;
  localparam logic [11:0] OFF_CSIZE = 12'h058;
  localparam logic [11:0] OFF_CLO   = 12'h05C;
  localparam logic [11:0] OFF_CHI   = 12'h060;
  localparam logic [11:0] OFF_RSIZE = 12'h064;
  localparam logic [11:0] OFF_RADDR = 12'h068;
  localparam logic [11:0] OFF_BUF   = 12'h080;

  localparam int IFID_SEL_BIT  = 17;
  localparam int IFID_LOCK_BIT = 19;
  localparam int IFID_CAP_BIT  = 14;

  function automatic logic [31:0] buf_size_bytes(input int unsigned words);
    return 32'(words * 4);
  endfunction

  function automatic logic [31:0] buf_location(input logic [31:0] base);
    return base + {20'd0, OFF_BUF};
  endfunction

  function automatic logic [31:0] ifid_word(input logic sel, input logic lock);
    logic [31:0] w;
    w = '0;
    w[3:0] = sel ? 4'h1 : 4'h0;
    w[IFID_CAP_BIT] = 1'b1;
    w[IFID_SEL_BIT] = sel;
    w[IFID_LOCK_BIT] = lock;
    return w;
  endfunction
endpackage

// File: rtl/crb_ifid.sv
module crb_ifid (
  input  logic clk,
  input  logic rst_n,
  input  logic id_wr,
  input  logic wr_sel,
  input  logic wr_lock,
  output logic sel_o,
  output logic lock_o
);
  logic sel_q, lock_q;
  logic upd_ok;
  assign upd_ok = id_wr && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (upd_ok) begin
      if (wr_lock) lock_q <= 1'b1;
      else         sel_q  <= wr_sel;
    end
  end

  assign sel_o  = sel_q;
  assign lock_o = lock_q;

  assert_lock_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(sel_q) && lock_q));
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic start_wr,
  input  logic be_done_i,
  input  logic be_err_i,
  output logic req_o,
  output logic start_o,
  output logic err_o,
  output logic be_start_o
);
  logic req_q, start_q, err_q, pulse_q;
  logic launch, finish;

  assign launch = start_wr && !start_q;
  assign finish = start_q && (be_done_i || be_err_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      req_q   <= req_wr;
      pulse_q <= launch;
      if (launch) begin
        start_q <= 1'b1;
        err_q   <= 1'b0;
      end else if (finish) begin
        start_q <= 1'b0;
        err_q   <= be_err_i;
      end
    end
  end

  assign req_o      = req_q;
  assign start_o    = start_q;
  assign err_o      = err_q;
  assign be_start_o = pulse_q;

  assert_ready_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !req_wr) |=> !req_q);
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (start_q && !$past(start_q)));
  assert_start_ends_on_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> $past(be_done_i || be_err_i));
  assert_err_from_backend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(be_err_i && start_q));
endmodule

// File: rtl/crb_buffer.sv
module crb_buffer #(
  parameter int WORDS = 16,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  logic [31:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(g))) mem[g] <= wdata;
    end
  end

  assign rdata = (int'(ridx) < WORDS) ? mem[ridx] : 32'd0;
endmodule

// File: rtl/crb_regblock.sv
module crb_regblock #(
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter int          BUF_WORDS = 16,
  parameter int          LOC_W     = 3,
  localparam int ADDR_W = LOC_W + 12,
  localparam int IDX_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              be_start,
  input  logic              be_done,
  input  logic              be_err
);
  import crb_pkg::*;

  localparam int BUF_END = int'(OFF_BUF) + 4 * BUF_WORDS;

  logic        loc0;
  logic [11:0] off;
  logic [11:0] boff;
  logic        buf_hit;
  logic        wr_ok;
  logic [IDX_W-1:0] bidx;
  logic [31:0] buf_rd;
  logic sel, lock, req, start, err;

  assign loc0    = (bus_addr[ADDR_W-1:12] == '0);
  assign off     = {bus_addr[11:2], 2'b00};
  assign boff    = off - OFF_BUF;
  assign buf_hit = (off >= OFF_BUF) && (int'(off) < BUF_END);
  assign bidx    = boff[IDX_W+1:2];
  assign wr_ok   = bus_wr && loc0;

  crb_ifid u_ifid (
    .clk(clk), .rst_n(rst_n),
    .id_wr(wr_ok && off == OFF_IFID),
    .wr_sel(bus_wdata[IFID_SEL_BIT]),
    .wr_lock(bus_wdata[IFID_LOCK_BIT]),
    .sel_o(sel), .lock_o(lock)
  );

  crb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_wr(wr_ok && off == OFF_REQ && bus_wdata[0]),
    .start_wr(wr_ok && off == OFF_START && bus_wdata[0]),
    .be_done_i(be_done), .be_err_i(be_err),
    .req_o(req), .start_o(start), .err_o(err),
    .be_start_o(be_start)
  );

  crb_buffer #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk),
    .we(wr_ok && buf_hit),
    .widx(bidx),
    .wdata(bus_wdata),
    .ridx(bidx),
    .rdata(buf_rd)
  );

  always_comb begin
    bus_rdata = 32'd0;
    if (loc0) begin
      if (buf_hit) bus_rdata = buf_rd;
      else begin
        case (off)
          OFF_IFID:  bus_rdata = ifid_word(sel, lock);
          OFF_REQ:   bus_rdata = {31'd0, req};
          OFF_STS:   bus_rdata = {31'd0, err};
          OFF_START: bus_rdata = {31'd0, start};
          OFF_CSIZE, OFF_RSIZE: bus_rdata = buf_size_bytes(BUF_WORDS);
          OFF_CLO, OFF_RADDR:   bus_rdata = buf_location(BASE_ADDR);
          default:   bus_rdata = 32'd0;
        endcase
      end
    end
  end

  assert_other_loc_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !loc0 |-> (bus_rdata == 32'd0));
  assert_cmd_high_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc0 && off == OFF_CHI) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/crb_regblock_bench.sv
module crb_regblock_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFED4_0000;
  localparam int WORDS = 16;
  localparam int LOCW = 3;
  localparam int AW = LOCW + 12;

  logic clk = 0, rst_n = 0, bus_wr = 0, be_done = 0, be_err = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic be_start;
  int n_chk = 0, n_bad = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  crb_regblock #(.BASE_ADDR(BASE), .BUF_WORDS(WORDS), .LOC_W(LOCW)) u_crb_regblock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .be_start(be_start),
    .be_done(be_done), .be_err(be_err));

  function automatic logic [31:0] exp_id(input bit s, input bit l);
    return (32'(l) << 19) | (32'(s) << 17) | (32'd1 << 14) | 32'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    do_reset();
    // R1 reset state
    rd(AW'('h030), v); check("R1 id", v, exp_id(0, 0));
    rd(AW'('h040), v); check("R1 req", v, 0);
    rd(AW'('h04C), v); check("R1 start", v, 0);
    rd(AW'('h044), v); check("R1 err", v, 0);
    check("R1 be_start", 32'(be_start), 0);
    // R3 lock before select: select ignored
    wr(AW'('h030), 32'h0008_0000);
    rd(AW'('h030), v); check("R3 locked", v, exp_id(0, 1));
    wr(AW'('h030), 32'h0002_0000);
    rd(AW'('h030), v); check("R3 select ignored", v, exp_id(0, 1));
    do_reset();
    rd(AW'('h030), v); check("R1 id after reset", v, exp_id(0, 0));
    // R2 select, deselect, select, then R3 lock
    wr(AW'('h030), 32'h0002_0000);
    rd(AW'('h030), v); check("R2 select", v, exp_id(1, 0));
    wr(AW'('h030), 32'h0);
    rd(AW'('h030), v); check("R2 deselect", v, exp_id(0, 0));
    wr(AW'('h030), 32'h0002_0000);
    wr(AW'('h030), 32'h0008_0000);
    rd(AW'('h030), v); check("R3 lock keeps select", v, exp_id(1, 1));
    wr(AW'('h030), 32'h0);
    rd(AW'('h030), v); check("R3 deselect ignored", v, exp_id(1, 1));
    // R4 ready handshake
    wr(AW'('h040), 32'h1);
    rd(AW'('h040), v); check("R4 req set", v, 1);
    @(negedge clk);
    rd(AW'('h040), v); check("R4 req cleared", v, 0);
    // R8 descriptor registers
    rd(AW'('h058), v); check("R8 cmd size", v, WORDS * 4);
    rd(AW'('h064), v); check("R8 rsp size", v, WORDS * 4);
    rd(AW'('h05C), v); check("R8 cmd addr", v, BASE + 32'h80);
    rd(AW'('h068), v); check("R8 rsp addr", v, BASE + 32'h80);
    rd(AW'('h060), v); check("R8 cmd high", v, 0);
    // R7 stray strobes while idle
    @(negedge clk); be_err = 1; @(negedge clk); be_err = 0;
    rd(AW'('h044), v); check("R7 stray err", v, 0);
    rd(AW'('h04C), v); check("R7 stray start", v, 0);
    // R5/R6 commands with random latency and outcome
    for (int k = 0; k < 20; k++) begin
      bit fail_it;
      int lat;
      fail_it = ($urandom % 3) == 0;
      lat = $urandom % 6;
      wr(AW'('h04C), 32'h1);
      check("R5 start pulse", 32'(be_start), 1);
      rd(AW'('h04C), v); check("R5 start busy", v, 1);
      rd(AW'('h044), v); check("R6 err cleared by start", v, 0);
      @(negedge clk);
      check("R5 pulse one cycle", 32'(be_start), 0);
      if (k == 3) begin
        wr(AW'('h04C), 32'h1);
        check("R7 no pulse while busy", 32'(be_start), 0);
      end
      repeat (lat) @(negedge clk);
      rd(AW'('h04C), v); check("R5 still busy", v, 1);
      if (fail_it) be_err = 1; else be_done = 1;
      @(negedge clk); be_err = 0; be_done = 0;
      rd(AW'('h04C), v); check("R5 start cleared", v, 0);
      rd(AW'('h044), v); check("R6 err status", v, 32'(fail_it));
      @(negedge clk); be_done = 1; @(negedge clk); be_done = 0;
      rd(AW'('h044), v); check("R7 stray done keeps err", v, 32'(fail_it));
    end
    // R9 buffer random writes and readback
    for (int i = 0; i < WORDS; i++) begin
      model[i] = $urandom;
      wr(AW'(12'h080 + 12'(4 * i)), model[i]);
    end
    for (int k = 0; k < 40; k++) begin
      int i;
      i = $urandom % WORDS;
      model[i] = $urandom;
      wr(AW'(12'h080 + 12'(4 * i)), model[i]);
    end
    for (int i = 0; i < WORDS; i++) begin
      rd(AW'(12'h080 + 12'(4 * i)), v); check("R9 buffer word", v, model[i]);
    end
    // R10 undefined and stub offsets
    begin
      logic [11:0] offs [8] = '{12'h000, 12'h008, 12'h00C, 12'h038, 12'h048, 12'h050, 12'h054, 12'h400};
      for (int i = 0; i < 8; i++) begin
        wr(AW'(offs[i]), 32'hFFFF_FFFF);
        rd(AW'(offs[i]), v); check("R10 reads zero", v, 0);
      end
      rd(AW'('h030), v); check("R10 id untouched", v, exp_id(1, 1));
      rd(AW'('h04C), v); check("R10 start untouched", v, 0);
      rd(AW'('h080), v); check("R10 buffer untouched", v, model[0]);
    end
    // R11 other localities
    for (int l = 1; l < 4; l++) begin
      logic [AW-1:0] a;
      a = {LOCW'(l), 12'h080};
      wr(a, 32'h1234_5678);
      rd(a, v); check("R11 other loc read", v, 0);
      wr({LOCW'(l), 12'h04C}, 32'h1);
      check("R11 no start pulse", 32'(be_start), 0);
    end
    rd(AW'('h080), v); check("R11 loc0 buffer intact", v, model[0]);
    rd(AW'('h04C), v); check("R11 loc0 start idle", v, 0);
    summary();
  end
endmodule